// File: doc/BRIEF.md
# Bus Activity Monitor with Watermark Interrupts

This block watches bus activity on a configurable number of channels (two by default). Every cycle in which a channel's event input is high adds a programmable weight to that channel's running count. A shared period timer, advanced by a one-cycle tick from a slow time base, closes a sampling period every (P+1) ticks. At each period boundary every running channel compares its raw count against an upper and a lower watermark. It also updates an exponentially smoothed average, using a window of 2^(K+1) periods, and compares that average against a second pair of watermarks. It then restarts the count.

A raw-count breach raises a sticky status bit only after a programmed number of back-to-back breaching periods. A period that does not breach restarts that run. Average breaches raise their status bits in the period they happen. Each channel drives its own interrupt term from its enabled status bits. A global status word shows the term for each channel, and the `irq` output is the OR of all of them. Software programs and reads the block through plain register strobes with an address. Read data appears one cycle after the read strobe.

Top module: `actmon_top`

## Requirements
- R1: A sampling period closes on the tick that brings the tick count since the last close to P+1, where P is the 8-bit value at global offset 0x04. No period-end processing happens before that tick.
- R2: While a channel's control bit 31 is clear, its event input adds nothing: the count held when the channel is re-enabled is zero. Each event cycle of a running channel adds the weight register value (offset 0x18), saturating at all ones.
- R3: At a period end, avg becomes avg − (avg >> (K+1)) + (count >> (K+1)), with K in control bits 12:10. A write to offset 0x0C loads the average directly. The average reads at offset 0x20.
- R4: With control bit 30 set, a count strictly above the upper watermark (0x04) for N consecutive periods sets status bit 31. N is control bits 28:26 plus one.
- R5: With control bit 29 set, a count strictly below the lower watermark (0x08) for N consecutive periods sets status bit 30. N is control bits 25:23 plus one. Any non-breaching period restarts the run.
- R6: At a period end, a new average above offset 0x10 sets status bit 29 when control bit 21 is set. A new average below offset 0x14 sets status bit 28 when control bit 20 is set.
- R7: Writing the status register (0x24) clears each bit written as one. Writing all ones clears it.
- R8: Global status (offset 0x00) bit 26 is the interrupt of channel 0 and bit 25 that of channel 1. A channel's interrupt is any status bit whose enable control bit is set. `irq` is the OR of these.
- R9: Period-end processing needs both control bit 31 and control bit 18. Without bit 18, periods leave the average and status unchanged.
- R10: Registers read back their written values, and 0 after reset. The channel register base is 0x40 × (channel + 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle time-base pulse |
| evt | input | NCH | Per-channel activity event |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Register byte address |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data, valid the cycle after rd_en |
| irq | output | 1 | OR of all channel interrupts |

## Verification
Counts of 24, 4, 12 and 20 are driven against watermarks of 20 and 8. This separates a single-period above breach, a three-period below run, a run broken by one in-band period, and a neutral period. Seeded averages of 100, 80, 200 and 40 tell the window shift apart from K and from the two average comparisons. Stop and no-periodic phases show that events are dropped and periods are ignored. A second channel shows that the global status bit positions are distinct.

// File: rtl/actmon_pkg.sv
package actmon_pkg;
  localparam int unsigned OFF_W = 6;
  localparam logic [OFF_W-1:0] O_CTRL  = 6'h00;
  localparam logic [OFF_W-1:0] O_UPW   = 6'h04;
  localparam logic [OFF_W-1:0] O_LOW   = 6'h08;
  localparam logic [OFF_W-1:0] O_SEED  = 6'h0C;
  localparam logic [OFF_W-1:0] O_AUP   = 6'h10;
  localparam logic [OFF_W-1:0] O_ALO   = 6'h14;
  localparam logic [OFF_W-1:0] O_WGT   = 6'h18;
  localparam logic [OFF_W-1:0] O_AVG   = 6'h20;
  localparam logic [OFF_W-1:0] O_STS   = 6'h24;
  localparam logic [OFF_W-1:0] O_GSTS  = 6'h00;
  localparam logic [OFF_W-1:0] O_GPER  = 6'h04;
  // control bit positions
  localparam int unsigned C_K      = 10;
  localparam int unsigned C_PERIOD = 18;
  localparam int unsigned C_ALO_EN = 20;
  localparam int unsigned C_AUP_EN = 21;
  localparam int unsigned C_NDN    = 23;
  localparam int unsigned C_NUP    = 26;
  localparam int unsigned C_DN_EN  = 29;
  localparam int unsigned C_UP_EN  = 30;
  localparam int unsigned C_RUN    = 31;
  localparam int unsigned FLD_W    = 3;
  // status: four sticky flags mapped to bits 31..28
  localparam int unsigned STS_LSB  = 28;
  localparam int unsigned GIRQ_TOP = 26;
endpackage

// File: rtl/actmon_timer.sv
module actmon_timer #(
  parameter int unsigned PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [PW-1:0] period,
  output logic          pend
);
  logic [PW-1:0] tcnt_q, tcnt_d;

  always_comb begin
    pend   = tick && (tcnt_q >= period);
    tcnt_d = tcnt_q;
    if (pend)      tcnt_d = '0;
    else if (tick) tcnt_d = tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pend |=> (tcnt_q == '0));
endmodule

// File: rtl/actmon_streak.sv
module actmon_streak #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          step,
  input  logic          hit,
  input  logic [CW-1:0] need,
  output logic          fire
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full;

  always_comb begin
    full  = (cnt_q >= need);
    fire  = en && step && hit && full;
    cnt_d = cnt_q;
    if (!en)              cnt_d = '0;
    else if (step) begin
      if (!hit || full)   cnt_d = '0;
      else                cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  p_fire_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (cnt_q == '0));
endmodule

// File: rtl/actmon_chan.sv
module actmon_chan
  import actmon_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             pend,
  input  logic             wr,
  input  logic [OFF_W-1:0] off,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rd_val,
  output logic             irq
);
  localparam int unsigned NSTS = DW - STS_LSB;

  logic [DW-1:0]   ctrl_q, upw_q, low_q, aup_q, alo_q, wgt_q, avg_q, acc_q;
  logic [DW-1:0]   acc_d, avg_d, avg_nx, acc_sum;
  logic [NSTS-1:0] sts_q, sts_d, sts_set, sts_msk;
  logic [DW:0]     acc_wide;
  logic [FLD_W:0]  sh;
  logic            run, samp, above, below, fire_up, fire_dn, wr_seed, wr_sts;

  assign run     = ctrl_q[C_RUN] && ctrl_q[C_PERIOD];
  assign samp    = pend && run;
  assign sh      = {1'b0, ctrl_q[C_K +: FLD_W]} + 1'b1;
  assign above   = acc_q > upw_q;
  assign below   = acc_q < low_q;
  assign wr_seed = wr && (off == O_SEED);
  assign wr_sts  = wr && (off == O_STS);

  actmon_streak #(.CW(FLD_W)) u_up (
    .clk(clk), .rst_n(rst_n), .en(run && ctrl_q[C_UP_EN]), .step(pend),
    .hit(above), .need(ctrl_q[C_NUP +: FLD_W]), .fire(fire_up));
  actmon_streak #(.CW(FLD_W)) u_dn (
    .clk(clk), .rst_n(rst_n), .en(run && ctrl_q[C_DN_EN]), .step(pend),
    .hit(below), .need(ctrl_q[C_NDN +: FLD_W]), .fire(fire_dn));

  // next-state: accumulator and average
  always_comb begin
    acc_wide = {1'b0, acc_q} + {1'b0, wgt_q};
    acc_sum  = acc_wide[DW] ? '1 : acc_wide[DW-1:0];
    acc_d    = acc_q;
    if (!run)      acc_d = '0;
    else if (samp) acc_d = evt ? wgt_q : '0;
    else if (evt)  acc_d = acc_sum;
    avg_nx = avg_q - (avg_q >> sh) + (acc_q >> sh);
    avg_d  = avg_q;
    if (wr_seed)   avg_d = wdata;
    else if (samp) avg_d = avg_nx;
  end

  // next-state: sticky status
  always_comb begin
    sts_set    = '0;
    sts_set[3] = fire_up;
    sts_set[2] = fire_dn;
    sts_set[1] = samp && ctrl_q[C_AUP_EN] && (avg_nx > aup_q);
    sts_set[0] = samp && ctrl_q[C_ALO_EN] && (avg_nx < alo_q);
    sts_d      = sts_q;
    if (wr_sts) sts_d = sts_q & ~wdata[DW-1:STS_LSB];
    sts_d      = sts_d | sts_set;
    sts_msk    = {ctrl_q[C_UP_EN], ctrl_q[C_DN_EN], ctrl_q[C_AUP_EN], ctrl_q[C_ALO_EN]};
  end

  assign irq = |(sts_q & sts_msk);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0; upw_q <= '0; low_q <= '0; aup_q <= '0;
      alo_q  <= '0; wgt_q <= '0; avg_q <= '0; acc_q <= '0; sts_q <= '0;
    end else begin
      acc_q <= acc_d;
      avg_q <= avg_d;
      sts_q <= sts_d;
      if (wr && off == O_CTRL) ctrl_q <= wdata;
      if (wr && off == O_UPW)  upw_q  <= wdata;
      if (wr && off == O_LOW)  low_q  <= wdata;
      if (wr && off == O_AUP)  aup_q  <= wdata;
      if (wr && off == O_ALO)  alo_q  <= wdata;
      if (wr && off == O_WGT)  wgt_q  <= wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    case (off)
      O_CTRL:  rd_val = ctrl_q;
      O_UPW:   rd_val = upw_q;
      O_LOW:   rd_val = low_q;
      O_AUP:   rd_val = aup_q;
      O_ALO:   rd_val = alo_q;
      O_WGT:   rd_val = wgt_q;
      O_AVG:   rd_val = avg_q;
      O_STS:   rd_val = {sts_q, {STS_LSB{1'b0}}};
      default: rd_val = '0;
    endcase
  end

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !wr_seed) |=> $stable(avg_q));
  p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sts && (wdata == '1) && !samp) |=> (sts_q == '0));
  p_up_on_period_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts_q[3]) |-> $past(samp));
  p_stop_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[C_RUN] |=> (acc_q == '0));
endmodule

// File: rtl/actmon_top.sv
module actmon_top
  import actmon_pkg::*;
#(
  parameter int unsigned NCH = 2,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32,
  parameter int unsigned PW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [NCH-1:0] evt,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  rdata,
  output logic           irq
);
  localparam int unsigned SELW = AW - OFF_W;

  logic                   rs_meta, rs_n;
  logic [PW-1:0]          per_q;
  logic                   pend;
  logic [NCH-1:0]         ch_irq, ch_sel;
  logic [NCH-1:0][DW-1:0] ch_rd;
  logic [DW-1:0]          glob, rd_mux, rdata_q;
  logic [OFF_W-1:0]       off;
  logic [SELW-1:0]        sel;
  logic                   g_sel;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin rs_meta <= 1'b0; rs_n <= 1'b0; end
    else        begin rs_meta <= 1'b1; rs_n <= rs_meta; end
  end

  assign off   = addr[OFF_W-1:0];
  assign sel   = addr[AW-1:OFF_W];
  assign g_sel = (sel == '0);

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) per_q <= '0;
    else if (wr_en && g_sel && off == O_GPER) per_q <= wdata[PW-1:0];
  end

  actmon_timer #(.PW(PW)) u_tmr (
    .clk(clk), .rst_n(rs_n), .tick(tick), .period(per_q), .pend(pend));

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign ch_sel[g] = (sel == SELW'(g + 1));
    actmon_chan #(.DW(DW)) u_ch (
      .clk(clk), .rst_n(rs_n), .evt(evt[g]), .pend(pend),
      .wr(wr_en && ch_sel[g]), .off(off), .wdata(wdata),
      .rd_val(ch_rd[g]), .irq(ch_irq[g]));
  end

  always_comb begin
    glob = '0;
    for (int i = 0; i < NCH; i++) glob[GIRQ_TOP - i] = ch_irq[i];
    rd_mux = '0;
    if (g_sel) begin
      if (off == O_GSTS)      rd_mux = glob;
      else if (off == O_GPER) rd_mux = DW'(per_q);
    end else begin
      for (int i = 0; i < NCH; i++) if (ch_sel[i]) rd_mux = ch_rd[i];
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n)      rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_mux;
  end

  assign rdata = rdata_q;
  assign irq   = |ch_irq;

  p_irq_src_r8: assert property (@(posedge clk) disable iff (!rs_n)
    $rose(irq) |-> $past(pend || wr_en));
endmodule

// File: tb/tb_actmon_top.sv
`timescale 1ns/1ps
module tb_actmon_top;
  logic        clk = 1'b0;
  logic        rst_n, tick, wr_en, rd_en;
  logic [1:0]  evt;
  logic [7:0]  addr;
  logic [31:0] wdata, rdata;
  logic        irq, rd_pend;
  int          n_chk = 0, n_fail = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #2.5 clk = ~clk;

  actmon_top dut (.clk(clk), .rst_n(rst_n), .tick(tick), .evt(evt),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq));

  localparam logic [31:0] CTL = 32'hE104_0000;

  always @(posedge clk) rd_pend <= rd_en;

  // monitor: compare read data against the scoreboard queue
  always @(negedge clk) begin
    if (rd_pend === 1'b1 && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata !== e) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", t, rdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e); tag_q.push_back(t);
    rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    n_chk++;
    if (irq !== e) begin
      n_fail++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic events(input int ch, input int k);
    for (int i = 0; i < k; i++) begin
      @(negedge clk); evt[ch] = 1'b1;
    end
    @(negedge clk); evt = '0;
  endtask

  task automatic period(input int ch, input int k);
    events(ch, k);
    ticks(3);
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; tick = 0; wr_en = 0; rd_en = 0; evt = '0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd(8'h40, 32'h0, "R10 ctrl reset");
    rd(8'h64, 32'h0, "R10 status reset");
    rd(8'h00, 32'h0, "R8 global reset");
    chk_irq(1'b0, "R8 irq reset");

    wr(8'h04, 32'd2);            // period of 3 ticks
    wr(8'h58, 32'd4);            // weight
    wr(8'h44, 32'd20);           // upper
    wr(8'h48, 32'd8);            // lower
    wr(8'h50, 32'hFFFF_FFFF);
    wr(8'h54, 32'h0);
    wr(8'h4C, 32'd20);           // seed
    wr(8'h40, CTL);
    rd(8'h44, 32'd20, "R10 upper readback");
    rd(8'h04, 32'd2, "R10 period readback");

    // R1 / R4: count 24 > 20, N=1
    events(0, 6);
    ticks(2);
    rd(8'h64, 32'h0, "R1 no close before P+1 ticks");
    ticks(1);
    rd(8'h64, 32'h8000_0000, "R4 above after one period");
    chk_irq(1'b1, "R8 irq on above");
    rd(8'h00, 32'h0400_0000, "R8 global bit 26");
    rd(8'h60, 32'd22, "R3 avg 20->22");

    // R7
    wr(8'h64, 32'hFFFF_FFFF);
    rd(8'h64, 32'h0, "R7 clear all");
    chk_irq(1'b0, "R7 irq cleared");

    // R5: count 4 < 8, N=3
    period(0, 1); period(0, 1);
    rd(8'h64, 32'h0, "R5 two low periods");
    period(0, 1);
    rd(8'h64, 32'h4000_0000, "R5 third low period");
    wr(8'h64, 32'hFFFF_FFFF);
    period(0, 1); period(0, 1); period(0, 3); period(0, 1); period(0, 1);
    rd(8'h64, 32'h0, "R5 run broken by in-band period");
    period(0, 1);
    rd(8'h64, 32'h4000_0000, "R5 run of three after break");
    wr(8'h64, 32'hFFFF_FFFF);

    // R3 average
    wr(8'h4C, 32'd100);
    period(0, 5);
    rd(8'h60, 32'd60, "R3 K=0 average");
    wr(8'h40, CTL | 32'h0000_0800);
    wr(8'h4C, 32'd80);
    period(0, 5);
    rd(8'h60, 32'd72, "R3 K=2 average");
    rd(8'h64, 32'h0, "R4 count equal to upper no breach");

    // R6 average watermarks
    wr(8'h50, 32'd50); wr(8'h54, 32'd45);
    wr(8'h40, 32'hE134_0000);
    wr(8'h4C, 32'd200);
    period(0, 5);
    rd(8'h64, 32'h2000_0000, "R6 avg above");
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h4C, 32'd40);
    period(0, 5);
    rd(8'h64, 32'h1000_0000, "R6 avg below");
    wr(8'h64, 32'hFFFF_FFFF);
    wr(8'h50, 32'hFFFF_FFFF); wr(8'h54, 32'h0);

    // R9 master without periodic
    wr(8'h40, 32'hC000_0000);
    wr(8'h4C, 32'd30);
    period(0, 6);
    rd(8'h64, 32'h0, "R9 no status without periodic");
    rd(8'h60, 32'd30, "R9 avg held without periodic");

    // R2 stopped channel drops events
    wr(8'h40, 32'h0);
    wr(8'h4C, 32'd0);
    events(0, 6);
    wr(8'h40, CTL);
    ticks(3);
    rd(8'h60, 32'd0, "R2 no stale count after stop");
    rd(8'h64, 32'h0, "R2 status quiet");

    // R8 channel 1
    wr(8'h40, 32'h0);
    wr(8'h98, 32'd1);
    wr(8'h84, 32'd2);
    wr(8'h88, 32'd0);
    wr(8'h80, 32'hC004_0000);
    period(1, 3);
    rd(8'hA4, 32'h8000_0000, "R4 channel 1 above");
    rd(8'h00, 32'h0200_0000, "R8 global bit 25");
    chk_irq(1'b1, "R8 irq from channel 1");

    repeat (5) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule